// File: doc/BRIEF.md
# Periodic InfoFrame Packet Scheduler

This block sits in front of a display transmitter and decides when an auxiliary video-information packet goes out. Software stages a four-word payload through a small register write port and then commits it with an update bit that clears itself. The commit copies the staged words into a transmit copy. When emission is enabled, the block sends that copy as one four-beat packet on a valid/ready stream. The packet starts on the strobe that marks the start of vertical blanking. It goes out on every frame, or only on every second frame.

Packets always hold a consistent payload. A commit that arrives while a packet is in flight waits until the last beat has been accepted. The staged words can be rewritten at any time without disturbing what is being sent. The block also holds the number of packet slots allowed per blanking zone, one value for horizontal blanking and one for vertical blanking. Each value is presented with a floor applied, so downstream framing never sees a value below the minimum.

Top module: `vidinfo_pkt_sched`

## Requirements
- R1: After reset, `pktValid` is 0, the control register (address 4) reads 0, the zone register (address 5) reads 0, and both effective slot outputs are 48.
- R2: Addresses 0 to 3 hold staged payload words 0 to 3 and read back as written. A staged write alone never changes the words that are transmitted.
- R3: In the control register, bit 0 is enable, bit 1 selects every-other-frame mode and bit 2 is update. Writing bit 2 as 1 makes it read 1 from the cycle after the write until the staged words have been copied. When no packet is in flight, the copy happens one cycle after the write and the bit then reads 0.
- R4: While enable is 0, a vertical-blank strobe starts no packet.
- R5: With enable 1 and bit 1 at 0, every vertical-blank strobe that arrives while idle starts a packet.
- R6: With enable 1 and bit 1 at 1, the strobes after enabling send, skip and send, in that order.
- R7: A packet is four beats carrying transmit words 0, 1, 2 and 3 in order, with `pktLast` high on the fourth beat only. `pktValid` rises in the cycle after the strobe.
- R8: An update written while a packet is in flight is deferred. That packet keeps the old words to its end, the update bit reads 1 until the copy, and the next packet carries the new words.
- R9: While `pktValid` is 1 and `pktReady` is 0, the beat holds: `pktValid` stays 1 and `pktData` is unchanged.
- R10: Address 5 holds the horizontal slot count in bits 15:0 and the vertical count in bits 31:16 and reads back raw. Each effective output is the stored value, or 48 if the stored value is smaller.
- R11: Clearing enable resets the frame parity, so the first strobe after re-enabling in every-other mode sends a packet.
- R12: A vertical-blank strobe during a packet is ignored. It neither restarts the packet nor queues a second one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address for write and read |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Combinational read data at `regAddr` |
| vblankStart | input | 1 | One-cycle start-of-vertical-blank strobe |
| pktValid | output | 1 | Packet beat valid |
| pktReady | input | 1 | Sink accepts the beat |
| pktData | output | 32 | Packet beat data |
| pktLast | output | 1 | Last beat of the packet |
| hZoneSlots | output | 16 | Effective horizontal-blank slot count |
| vZoneSlots | output | 16 | Effective vertical-blank slot count |

## Verification
The scheduler is driven with blanking strobes under three kinds of control setting:
- Disabled: shows that emission is gated.
- Every frame: shows the basic four-beat ordering.
- Every other frame: shows the send/skip cadence, and that re-enabling clears the parity.

A held-ready pattern pairs a mid-packet commit with a stray strobe. This separates a deferred copy from a torn packet, and an ignored strobe from a restart. The zone values below, at and above the floor, on each half, tell a correct clamp from an off-by-one or swapped-field clamp.

// File: rtl/vip_pkg.sv
package vip_pkg;
  localparam int PKT_WORDS = 4;
  localparam int BEAT_W    = $clog2(PKT_WORDS);
  localparam int ADDR_W    = 3;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_ZONE = 3'd5;

  localparam int CB_EN  = 0;
  localparam int CB_ALT = 1;
  localparam int CB_UPD = 2;

  typedef struct packed {
    logic              copyNow;
    logic              busy;
    logic              advance;
    logic [BEAT_W-1:0] beat;
  } ctlStrobe_t;
endpackage

// File: rtl/vip_sched_ctl.sv
module vip_sched_ctl
  import vip_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctrlWr,
  input  logic [2:0] ctrlBits,
  input  logic       vblankStart,
  input  logic       pktReady,
  output ctlStrobe_t strb,
  output logic       lastOut,
  output logic       enOut,
  output logic       altOut,
  output logic       pendOut
);
  localparam logic [BEAT_W-1:0] LAST_IDX = BEAT_W'(PKT_WORDS - 1);

  logic              enQ, altQ, pendQ, parityQ, busyQ;
  logic [BEAT_W-1:0] beatQ;
  logic              isLast, handshake, startNow, copyNow, updWr;

  always_comb begin
    isLast    = (beatQ == LAST_IDX);
    handshake = busyQ && pktReady;
    startNow  = vblankStart && enQ && !busyQ && (!altQ || !parityQ);
    copyNow   = pendQ && !busyQ;
    updWr     = ctrlWr && ctrlBits[CB_UPD];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ <= 1'b0; altQ <= 1'b0; pendQ <= 1'b0;
      parityQ <= 1'b0; busyQ <= 1'b0; beatQ <= '0;
    end else begin
      if (ctrlWr) begin
        enQ  <= ctrlBits[CB_EN];
        altQ <= ctrlBits[CB_ALT];
      end
      if (updWr) pendQ <= 1'b1;
      else if (copyNow) pendQ <= 1'b0;

      if (!enQ) parityQ <= 1'b0;
      else if (vblankStart) parityQ <= ~parityQ;

      if (startNow) begin
        busyQ <= 1'b1;
        beatQ <= '0;
      end else if (handshake) begin
        if (isLast) begin
          busyQ <= 1'b0;
          beatQ <= '0;
        end else begin
          beatQ <= beatQ + 1'b1;
        end
      end
    end
  end

  always_comb begin
    strb.copyNow = copyNow;
    strb.busy    = busyQ;
    strb.advance = handshake;
    strb.beat    = beatQ;
    lastOut      = busyQ && isLast;
    enOut        = enQ;
    altOut       = altQ;
    pendOut      = pendQ;
  end

  // R3: an idle scheduler performs a pending copy on the next edge
  a_r3_update_clears: assert property (@(posedge clk) disable iff (!rstN)
    (pendQ && !busyQ && !updWr) |=> !pendQ);
  // R4: a packet only starts from a strobe seen while enabled
  a_r4_start_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyQ) |-> $past(vblankStart && enQ));
  // R6: odd parity in every-other mode skips the frame
  a_r6_skip_odd_frame: assert property (@(posedge clk) disable iff (!rstN)
    (enQ && altQ && parityQ && vblankStart && !busyQ) |=> !busyQ);
  // R12: a stalled packet keeps its beat position
  a_r12_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && !pktReady) |=> (busyQ && $stable(beatQ)));
endmodule

// File: rtl/vip_sched_dp.sv
module vip_sched_dp
  import vip_pkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int ZONE_W   = 16,
  parameter int SLOT_MIN = 48
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [WORD_W-1:0] regWrData,
  input  ctlStrobe_t        strb,
  input  logic              enIn,
  input  logic              altIn,
  input  logic              pendIn,
  output logic [WORD_W-1:0] regRdData,
  output logic [WORD_W-1:0] pktData,
  output logic [ZONE_W-1:0] hZoneSlots,
  output logic [ZONE_W-1:0] vZoneSlots
);
  localparam logic [ZONE_W-1:0] FLOOR = ZONE_W'(SLOT_MIN);

  logic [PKT_WORDS-1:0][WORD_W-1:0] stageQ;
  logic [PKT_WORDS-1:0][WORD_W-1:0] txQ;
  logic [2*ZONE_W-1:0]              zoneQ;

  for (genvar i = 0; i < PKT_WORDS; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rstN) begin
        stageQ[i] <= '0;
        txQ[i]    <= '0;
      end else begin
        if (regWrEn && regAddr == ADDR_W'(i)) stageQ[i] <= regWrData;
        if (strb.copyNow) txQ[i] <= stageQ[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) zoneQ <= '0;
    else if (regWrEn && regAddr == ADDR_ZONE) zoneQ <= regWrData[2*ZONE_W-1:0];
  end

  logic [ZONE_W-1:0] hRaw, vRaw;
  always_comb begin
    hRaw       = zoneQ[ZONE_W-1:0];
    vRaw       = zoneQ[2*ZONE_W-1:ZONE_W];
    hZoneSlots = (hRaw < FLOOR) ? FLOOR : hRaw;
    vZoneSlots = (vRaw < FLOOR) ? FLOOR : vRaw;
    pktData    = strb.busy ? txQ[strb.beat] : '0;
  end

  always_comb begin
    regRdData = '0;
    if (regAddr < ADDR_W'(PKT_WORDS)) begin
      regRdData = stageQ[regAddr[BEAT_W-1:0]];
    end else if (regAddr == ADDR_CTRL) begin
      regRdData[CB_EN]  = enIn;
      regRdData[CB_ALT] = altIn;
      regRdData[CB_UPD] = pendIn;
    end else if (regAddr == ADDR_ZONE) begin
      regRdData[2*ZONE_W-1:0] = zoneQ;
    end
  end

  // R8: transmit copy is frozen while a packet is in flight
  a_r8_tx_frozen: assert property (@(posedge clk) disable iff (!rstN)
    strb.busy |=> $stable(txQ));
  // R10: effective slot counts never fall below the floor
  a_r10_slot_floor: assert property (@(posedge clk) disable iff (!rstN)
    (hZoneSlots >= FLOOR) && (vZoneSlots >= FLOOR));
endmodule

// File: rtl/vidinfo_pkt_sched.sv
module vidinfo_pkt_sched
  import vip_pkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int ZONE_W   = 16,
  parameter int SLOT_MIN = 48
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [WORD_W-1:0] regWrData,
  output logic [WORD_W-1:0] regRdData,
  input  logic              vblankStart,
  output logic              pktValid,
  input  logic              pktReady,
  output logic [WORD_W-1:0] pktData,
  output logic              pktLast,
  output logic [ZONE_W-1:0] hZoneSlots,
  output logic [ZONE_W-1:0] vZoneSlots
);
  ctlStrobe_t strb;
  logic       ctrlWr, enSig, altSig, pendSig, lastSig;

  assign ctrlWr = regWrEn && (regAddr == ADDR_CTRL);

  vip_sched_ctl u_ctl (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .ctrlBits(regWrData[2:0]),
    .vblankStart(vblankStart), .pktReady(pktReady), .strb(strb),
    .lastOut(lastSig), .enOut(enSig), .altOut(altSig), .pendOut(pendSig)
  );

  vip_sched_dp #(.WORD_W(WORD_W), .ZONE_W(ZONE_W), .SLOT_MIN(SLOT_MIN)) u_dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .strb(strb), .enIn(enSig), .altIn(altSig),
    .pendIn(pendSig), .regRdData(regRdData), .pktData(pktData),
    .hZoneSlots(hZoneSlots), .vZoneSlots(vZoneSlots)
  );

  assign pktValid = strb.busy;
  assign pktLast  = lastSig;

  // R7: last is only flagged on a valid beat
  a_r7_last_on_valid: assert property (@(posedge clk) disable iff (!rstN)
    pktLast |-> pktValid);
  // R9: a beat that is not accepted is held
  a_r9_hold_beat: assert property (@(posedge clk) disable iff (!rstN)
    (pktValid && !pktReady) |=> (pktValid && $stable(pktData)));
endmodule

// File: tb/vidinfo_pkt_sched_bench.sv
`timescale 1ns/1ps
module vidinfo_pkt_sched_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        vblankStart = 1'b0;
  logic        pktValid, pktReady = 1'b1, pktLast;
  logic [31:0] pktData;
  logic [15:0] hZoneSlots, vZoneSlots;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  vidinfo_pkt_sched u_vidinfo_pkt_sched (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .vblankStart(vblankStart),
    .pktValid(pktValid), .pktReady(pktReady), .pktData(pktData),
    .pktLast(pktLast), .hZoneSlots(hZoneSlots), .vZoneSlots(vZoneSlots)
  );

  // {write value, expected h, expected v}
  localparam logic [63:0] ZONE_VEC [6] = '{
    {32'h0000_0000, 16'd48,  16'd48},
    {32'h0030_002F, 16'd48,  16'd48},
    {32'h0031_0030, 16'd48,  16'd49},
    {32'hFFFF_0100, 16'd256, 16'hFFFF},
    {32'h0001_0064, 16'd100, 16'd48},
    {32'h002F_0031, 16'd49,  16'd48}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    regAddr = a;
    #0.5;
    d = regRdData;
  endtask

  task automatic vbl();
    @(negedge clk);
    vblankStart = 1'b1;
    @(negedge clk);
    vblankStart = 1'b0;
  endtask

  task automatic stageAll(input logic [31:0] base);
    for (int i = 0; i < 4; i++) wr(3'(i), base + 32'(i));
  endtask

  // sample a packet starting at the current negedge, ready held high
  task automatic getPkt(input string req, input logic [31:0] base);
    for (int b = 0; b < 4; b++) begin
      chk({req, " valid"}, {31'd0, pktValid}, 32'd1);
      chk({req, " data"}, pktData, base + 32'(b));
      chk({req, " last"}, {31'd0, pktLast}, {31'd0, (b == 3)});
      @(negedge clk);
    end
    chk({req, " idle after"}, {31'd0, pktValid}, 32'd0);
  endtask

  task automatic noPkt(input string req);
    for (int c = 0; c < 4; c++) begin
      chk(req, {31'd0, pktValid}, 32'd0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 valid", {31'd0, pktValid}, 32'd0);
    rd(3'd4, r); chk("R1 ctrl", r, 32'd0);
    rd(3'd5, r); chk("R1 zone", r, 32'd0);
    chk("R1 hslots", {16'd0, hZoneSlots}, 32'd48);
    chk("R1 vslots", {16'd0, vZoneSlots}, 32'd48);

    // R10 zone table
    for (int k = 0; k < 6; k++) begin
      wr(3'd5, ZONE_VEC[k][63:32]);
      rd(3'd5, r); chk("R10 raw", r, ZONE_VEC[k][63:32]);
      chk("R10 h", {16'd0, hZoneSlots}, {16'd0, ZONE_VEC[k][31:16]});
      chk("R10 v", {16'd0, vZoneSlots}, {16'd0, ZONE_VEC[k][15:0]});
    end

    // R2 staging readback
    stageAll(32'hA000_0000);
    for (int i = 0; i < 4; i++) begin
      rd(3'(i), r); chk("R2 readback", r, 32'hA000_0000 + 32'(i));
    end

    // R3 commit with enable off; R4 disabled gating
    wr(3'd4, 32'h4);
    rd(3'd4, r); chk("R3 update pending", r, 32'h4);
    @(negedge clk);
    rd(3'd4, r); chk("R3 update cleared", r, 32'h0);
    vbl();
    noPkt("R4 disabled no packet");

    // R5/R7 every frame
    wr(3'd4, 32'h1);
    rd(3'd4, r); chk("R3 ctrl bits", r, 32'h1);
    vbl(); getPkt("R7 first", 32'hA000_0000);
    wr(3'd0, 32'hC000_0000);   // R2: staged only, not committed
    vbl(); getPkt("R5 second frame", 32'hA000_0000);

    // R6 every other frame after a disable
    wr(3'd4, 32'h0);
    wr(3'd4, 32'h3);
    vbl(); getPkt("R6 first sends", 32'hA000_0000);
    vbl(); noPkt("R6 second skips");
    vbl(); getPkt("R6 third sends", 32'hA000_0000);

    // R11 parity reset on disable (parity now odd)
    wr(3'd4, 32'h0);
    wr(3'd4, 32'h3);
    vbl(); getPkt("R11 sends after reenable", 32'hA000_0000);

    // R8/R9/R12 deferred commit under backpressure
    wr(3'd4, 32'h1);
    @(negedge clk);
    pktReady = 1'b0;
    vbl();
    for (int c = 0; c < 3; c++) begin
      chk("R9 held valid", {31'd0, pktValid}, 32'd1);
      chk("R9 held data", pktData, 32'hA000_0000);
      @(negedge clk);
    end
    vbl();
    chk("R12 no restart", pktData, 32'hA000_0000);
    stageAll(32'hB000_0000);
    wr(3'd4, 32'h5);
    rd(3'd4, r); chk("R8 update pending in flight", r, 32'h5);
    chk("R8 old beat kept", pktData, 32'hA000_0000);
    pktReady = 1'b1;
    getPkt("R8 old packet intact", 32'hA000_0000);
    @(negedge clk);
    rd(3'd4, r); chk("R8 update cleared after packet", r, 32'h1);
    noPkt("R12 no queued packet");
    vbl(); getPkt("R8 new words", 32'hB000_0000);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule